// File: doc/BRIEF.md
# IF Frequency Window Checker

This block decides whether an intermediate-frequency signal sits close enough to its expected value to count as a received station. Its answer drives the stop decision of an automatic station search. The block takes a reference clock and an IF signal that is already at logic level. It counts the rising edges of that signal during a gate, and the gate length is derived from the reference clock. It then compares the count with the count that a signal exactly at the programmed centre frequency would give.

A programmable timer divides the reference clock down to a timer base tick. The intended base is 6.25 kHz for FM and 1 kHz for the AM modes. A 3-bit sample code then picks a gate of one to 128 ticks. At each gate start a signed down-counter is loaded with the expected edge count. Each detected rising edge takes one off the counter. At gate end the leftover count is the frequency error, and the block compares its magnitude with the tolerance that the window code selects.

The result is held on a level output until the next gate end, and a one-cycle strobe marks each new result. Changing the measurement settings throws away the gate in progress. Register values arrive on parallel inputs.

Top module: `if_window_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `searchStop` and `resValid` are both 0.
- R2: With `sampleCode` = s and `timerDiv` = d, a gate lasts 2^(7-s) x (d+1) reference cycles. Code 111 is the shortest gate and each lower code doubles it. Consecutive `resValid` pulses are exactly one gate length apart.
- R3: `mode` selects the expected edges per timer tick. 01 (FM) gives 1696 + CF. 10 (AM) gives 448 + CF. 11 (AM up-conversion) gives 10688 + CF. The expected count for a gate is that value times the number of ticks in the gate.
- R4: `centreCode` CF (0..31) raises the expected count by CF per tick, in every mode.
- R5: The tolerance per tick is 2^(w-3) counts for `windowCode` w in 3..7. Codes 0..2 act as code 3. A result is accepted when the absolute difference between the expected count and the edges counted in the gate is at most the tolerance times the number of ticks in the gate.
- R6: At each gate end `resValid` is 1 for exactly one cycle. In that same cycle `searchStop` shows the accept decision, and it holds that value until the next `resValid`.
- R7: While `enable` is 0 or `mode` is 00, no `resValid` is produced and `searchStop` is 0.
- R8: A change in `mode`, `centreCode`, `windowCode` or `sampleCode`, or the block becoming active, aborts the gate in progress. The next `resValid` then arrives one gate length plus one cycle after the clock edge that first sees the change.
- R9: Rising edges of `ifIn` are counted through a two-flop synchroniser, with one count per edge. The edge rate must stay below half the reference clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ifIn | input | 1 | IF signal at logic level, asynchronous to `clk` |
| enable | input | 1 | 1 runs measurements, 0 is standby |
| mode | input | 2 | 01 FM, 10 AM, 11 AM up-conversion, 00 idle |
| centreCode | input | 5 | Centre frequency step |
| windowCode | input | 3 | Window width, 3..7 (0..2 act as 3) |
| sampleCode | input | 3 | Gate length code, 111 shortest |
| timerDiv | input | 14 | Timer base divider, tick every timerDiv+1 cycles |
| searchStop | output | 1 | 1 when the last gate was inside the window |
| resValid | output | 1 | One-cycle strobe at each gate end |

## Verification
An IF stream with a period of exactly 4 cycles gives a known edge count in any gate. Against that count, the centre code is stepped so that the error lands exactly on the tolerance, just past it, and well past it. This separates a correct window width and window code clamping from an off-by-one or a missing shift. The same stream is then run with the sample code and the timer divider changed. This shows whether the gate scaling is applied to the expected count, to the tolerance and to the spacing between results. Switching between FM, AM and up-conversion shows the mode bases. A stream with a period of 5 cycles, together with standby, mode 00 and a settings change in mid-gate, separates real rejection, idling and gate abort from a design that simply keeps running.

// File: rtl/ifw_pkg.sv
package ifw_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_FM  = 2'b01,
    MODE_AM  = 2'b10,
    MODE_UPC = 2'b11
  } ifw_mode_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic active;   // measuring is allowed this cycle
    logic restart;  // begin a fresh gate, discard the current one
    logic gateEnd;  // last cycle of the current gate
  } ifw_strobe_t;
endpackage

// File: rtl/ifw_ctrl.sv
module ifw_ctrl
  import ifw_pkg::*;
#(
  parameter int TIMER_W  = 14,
  parameter int SAMPLE_W = 3,
  parameter int CFG_W    = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic [CFG_W-1:0]    cfgWord,
  input  logic [TIMER_W-1:0]  timerDiv,
  input  logic [SAMPLE_W-1:0] sampleCode,
  output ifw_strobe_t         strobes
);
  localparam int TICK_W = 2 ** SAMPLE_W;

  logic [TIMER_W-1:0]  preCnt;
  logic [TICK_W-1:0]   tickCnt;
  logic [TICK_W-1:0]   lastTick;
  logic [SAMPLE_W-1:0] gateShift;
  logic [CFG_W-1:0]    cfgQ;
  logic                activeQ;
  logic                isActive;
  logic                doRestart;
  logic                tickNow;

  assign isActive  = enable && (mode != MODE_OFF);
  assign doRestart = isActive && (!activeQ || (cfgWord != cfgQ));
  assign gateShift = ~sampleCode;
  assign lastTick  = (TICK_W'(1) << gateShift) - TICK_W'(1);
  assign tickNow   = (preCnt == timerDiv);

  assign strobes.active  = isActive;
  assign strobes.restart = doRestart;
  assign strobes.gateEnd = isActive && !doRestart && tickNow && (tickCnt == lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
      cfgQ    <= '0;
      activeQ <= 1'b0;
    end else begin
      activeQ <= isActive;
      cfgQ    <= cfgWord;
      if (!isActive || doRestart) begin
        preCnt  <= '0;
        tickCnt <= '0;
      end else if (tickNow) begin
        preCnt  <= '0;
        tickCnt <= (tickCnt == lastTick) ? '0 : tickCnt + TICK_W'(1);
      end else begin
        preCnt <= preCnt + TIMER_W'(1);
      end
    end
  end

  // R6: with a divider above zero, gate ends never fall on back-to-back cycles
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.gateEnd && (timerDiv != '0)) |=> !strobes.gateEnd);
endmodule

// File: rtl/ifw_datapath.sv
module ifw_datapath
  import ifw_pkg::*;
#(
  parameter int CNT_W    = 21,
  parameter int BASE_W   = 14,
  parameter int CF_W     = 5,
  parameter int SAMPLE_W = 3,
  parameter int FM_BASE  = 1696,
  parameter int AM_BASE  = 448,
  parameter int UPC_BASE = 10688
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ifIn,
  input  logic [1:0]          mode,
  input  logic [CF_W-1:0]     centreCode,
  input  logic [SAMPLE_W-1:0] windowCode,
  input  logic [SAMPLE_W-1:0] sampleCode,
  input  ifw_strobe_t         strobes,
  output logic                searchStop,
  output logic                resValid
);
  localparam int RES_W = CNT_W + 1;  // one sign bit for overshoot
  localparam logic [SAMPLE_W-1:0] WIN_MIN = SAMPLE_W'(3);

  logic [2:0]          syncQ;
  logic                riseEdge;
  logic [BASE_W-1:0]   perTick;
  logic [SAMPLE_W-1:0] gateShift;
  logic [SAMPLE_W-1:0] winSel;
  logic [SAMPLE_W:0]   tolShift;
  logic [RES_W-1:0]    expected;
  logic [RES_W-1:0]    tolerance;
  logic [RES_W-1:0]    mainCnt;
  logic [RES_W-1:0]    residual;
  logic [RES_W-1:0]    magnitude;
  logic                accept;

  // Two synchroniser flops, third flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], ifIn};
  end
  assign riseEdge = syncQ[1] && !syncQ[2];

  always_comb begin
    case (mode)
      MODE_FM:  perTick = BASE_W'(FM_BASE)  + BASE_W'(centreCode);
      MODE_AM:  perTick = BASE_W'(AM_BASE)  + BASE_W'(centreCode);
      MODE_UPC: perTick = BASE_W'(UPC_BASE) + BASE_W'(centreCode);
      default:  perTick = '0;
    endcase
  end

  assign gateShift = ~sampleCode;
  assign winSel    = (windowCode < WIN_MIN) ? '0 : windowCode - WIN_MIN;
  assign tolShift  = (SAMPLE_W+1)'(gateShift) + (SAMPLE_W+1)'(winSel);
  assign expected  = RES_W'(perTick) << gateShift;
  assign tolerance = RES_W'(1) << tolShift;
  assign residual  = mainCnt - RES_W'(riseEdge);
  assign magnitude = residual[RES_W-1] ? (~residual + RES_W'(1)) : residual;
  assign accept    = (magnitude <= tolerance);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt    <= '0;
      searchStop <= 1'b0;
      resValid   <= 1'b0;
    end else begin
      resValid <= strobes.gateEnd;
      if (!strobes.active) begin
        searchStop <= 1'b0;
      end else if (strobes.gateEnd) begin
        searchStop <= accept;
      end
      if (strobes.restart || strobes.gateEnd) begin
        mainCnt <= expected;
      end else if (strobes.active && riseEdge) begin
        mainCnt <= mainCnt - RES_W'(1);
      end
    end
  end

  // R7: idle cycles never yield a result and force the stop flag low
  a_r7_no_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |=> !resValid);
  a_r7_stop_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |=> !searchStop);
  // R6: the flag only moves together with a result strobe while active
  a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!resValid && $past(strobes.active)) |-> $stable(searchStop));
endmodule

// File: rtl/if_window_counter.sv
module if_window_counter
  import ifw_pkg::*;
#(
  parameter int TIMER_W  = 14,
  parameter int CNT_W    = 21,
  parameter int CF_W     = 5,
  parameter int SAMPLE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ifIn,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic [CF_W-1:0]     centreCode,
  input  logic [SAMPLE_W-1:0] windowCode,
  input  logic [SAMPLE_W-1:0] sampleCode,
  input  logic [TIMER_W-1:0]  timerDiv,
  output logic                searchStop,
  output logic                resValid
);
  localparam int CFG_W = 2 + CF_W + 2 * SAMPLE_W;

  ifw_strobe_t      strobes;
  logic [CFG_W-1:0] cfgWord;

  assign cfgWord = {mode, centreCode, windowCode, sampleCode};

  ifw_ctrl #(
    .TIMER_W(TIMER_W), .SAMPLE_W(SAMPLE_W), .CFG_W(CFG_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .cfgWord(cfgWord), .timerDiv(timerDiv), .sampleCode(sampleCode),
    .strobes(strobes)
  );

  ifw_datapath #(
    .CNT_W(CNT_W), .CF_W(CF_W), .SAMPLE_W(SAMPLE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ifIn(ifIn), .mode(mode),
    .centreCode(centreCode), .windowCode(windowCode),
    .sampleCode(sampleCode), .strobes(strobes),
    .searchStop(searchStop), .resValid(resValid)
  );
endmodule

// File: tb/if_window_counter_test.sv
module if_window_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ifIn = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  centreCode = '0;
  logic [2:0]  windowCode = 3'd3;
  logic [2:0]  sampleCode = 3'd7;
  logic [13:0] timerDiv = 14'd1791;
  logic        searchStop;
  logic        resValid;

  typedef struct {
    bit    accept;
    int    interval;
    string tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastMark = 0;
  int ifPeriod = 4;
  int ifPhase = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;

  if_window_counter uut (
    .clk(clk), .rstN(rstN), .ifIn(ifIn), .enable(enable), .mode(mode),
    .centreCode(centreCode), .windowCode(windowCode),
    .sampleCode(sampleCode), .timerDiv(timerDiv),
    .searchStop(searchStop), .resValid(resValid)
  );

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // IF stream: high for 2 cycles, low for the rest of the period
  always @(negedge clk) begin
    ifPhase <= (ifPhase + 1 >= ifPeriod) ? 0 : ifPhase + 1;
    ifIn    <= (ifPhase < 2);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model built from R2, R3, R4, R5
  function automatic bit predict(input int m, input int cf, input int ew,
                                 input int sc, input int div, input int per);
    int ticks, base, edges, expCnt, mag, tol;
    ticks  = 1 << (7 - sc);
    base   = (m == 1) ? 1696 : (m == 2) ? 448 : 10688;
    edges  = (ticks * (div + 1)) / per;
    expCnt = (base + cf) * ticks;
    mag    = (expCnt > edges) ? expCnt - edges : edges - expCnt;
    tol    = (1 << ((ew < 3) ? 0 : ew - 3)) * ticks;
    return mag <= tol;
  endfunction

  // Driver: wait for the scoreboard to drain, apply settings, push expectations
  task automatic apply(input int m, input int cf, input int ew, input int sc,
                       input int div, input bit en, input int per,
                       input int n, input string tag);
    int gateLen;
    bit acc;
    @(posedge clk);
    while (sb.size() != 0) @(posedge clk);
    @(negedge clk);
    mode = 2'(m); centreCode = 5'(cf); windowCode = 3'(ew);
    sampleCode = 3'(sc); timerDiv = 14'(div); enable = en;
    ifPeriod = per;
    lastMark = cyc;
    gateLen = (1 << (7 - sc)) * (div + 1);
    acc = predict(m, cf, ew, sc, div, per);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.accept   = acc;
      it.interval = (i == 0) ? gateLen + 1 : gateLen;
      it.tag      = tag;
      sb.push_back(it);
    end
  endtask

  task automatic drain();
    @(posedge clk);
    while (sb.size() != 0) @(posedge clk);
  endtask

  // Monitor: compare each result against the queue
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (quiet) begin
        check("R7 no result while idle", 1, 0);
      end else if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " searchStop"}, int'(searchStop), int'(it.accept));
        check({it.tag, " R6 R8 result spacing"}, cyc - lastMark, it.interval);
      end
      lastMark = cyc;
    end
  end

  task automatic quietFor(input int n, input string req);
    bit sawHigh;
    sawHigh = 1'b0;
    quiet = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (searchStop) sawHigh = 1'b1;
    end
    quiet = 1'b0;
    check({req, " searchStop low while idle"}, int'(sawHigh), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset searchStop", int'(searchStop), 0);
    check("R1 reset resValid", int'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release searchStop", int'(searchStop), 0);
    check("R1 after release resValid", int'(resValid), 0);

    // R3 R9: AM at exact centre, period-4 stream gives 448 edges per tick
    apply(2, 0, 3, 7, 1791, 1, 4, 3, "R9 R3 AM centre");
    // R5: slower stream falls far outside the window
    apply(2, 0, 5, 7, 1791, 1, 5, 2, "R5 AM off-frequency");
    // R4: centre shift of 2 within tolerance 4
    apply(2, 2, 5, 7, 1791, 1, 4, 2, "R4 AM centre 2");
    apply(2, 31, 7, 7, 1791, 1, 4, 2, "R4 AM centre 31");
    // R5: error of 10 against widening windows
    apply(2, 10, 5, 7, 1791, 1, 4, 2, "R5 window 5");
    apply(2, 10, 6, 7, 1791, 1, 4, 2, "R5 window 6");
    apply(2, 10, 7, 7, 1791, 1, 4, 2, "R5 window 7");
    // R5: reserved window code acts as code 3 (tolerance 1)
    apply(2, 1, 1, 7, 1791, 1, 4, 2, "R5 window code 1 edge");
    apply(2, 2, 0, 7, 1791, 1, 4, 2, "R5 window code 0 over");
    // R2: four-tick gate scales count, tolerance and spacing
    apply(2, 1, 3, 5, 1791, 1, 4, 2, "R2 gate code 5 edge");
    apply(2, 3, 3, 5, 1791, 1, 4, 2, "R2 gate code 5 over");
    apply(2, 0, 4, 6, 1791, 1, 4, 2, "R2 gate code 6");
    // R3: other modes with the same stream
    apply(3, 0, 7, 7, 1791, 1, 4, 2, "R3 up-conversion");
    apply(1, 0, 7, 7, 1791, 1, 4, 2, "R3 FM wrong base");
    apply(1, 0, 3, 7, 6783, 1, 4, 2, "R3 FM centre");
    apply(1, 1, 3, 7, 6783, 1, 4, 2, "R3 FM centre 1");
    apply(1, 2, 3, 7, 6783, 1, 4, 2, "R3 FM centre 2");
    drain();

    // R7: standby and idle mode
    apply(2, 0, 3, 7, 1791, 0, 4, 0, "R7 standby");
    quietFor(4000, "R7 enable low");
    apply(0, 0, 3, 7, 1791, 1, 4, 0, "R7 mode 00");
    quietFor(4000, "R7 mode 00");
    // R8: becoming active starts a full gate
    apply(2, 0, 3, 7, 1791, 1, 4, 2, "R8 activation");
    drain();
    // R8: a settings change in mid-gate aborts it
    apply(2, 0, 3, 7, 1791, 1, 4, 0, "R8 first settings");
    repeat (900) @(negedge clk);
    apply(2, 1, 3, 7, 1791, 1, 4, 2, "R8 mid-gate change");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired with %0d results pending", sb.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule